// File: doc/BRIEF.md
# CRC-32 Calculator Peripheral

This block is a memory-mapped CRC-32 calculator behind an AXI4-Lite slave port with a 32-bit data path. Software seeds an accumulator and then writes 32-bit words, one at a time, to the data register. Each write folds the whole word into the running CRC in a single clock cycle. A read of the same register returns the accumulated checksum, not the word that was last written.

A control register selects how input bits are reordered before the update: no change, mirrored within each byte, mirrored within each half-word, or mirrored across the whole word. It can also mirror the result on read. Writing its self-clearing restart bit reloads the accumulator from a programmable seed register.

The register file also has a scratch word that is unrelated to the CRC, and a read-only polynomial word. Word offsets are decoded from address bits 4:2, and address bits 1:0 are ignored.

Top module: `crc_calc_axil`

## Requirements
- R1: A write is accepted in the cycle where AWVALID and WVALID are both high and no write response is pending. BVALID rises on the next cycle with BRESP = 0 (OKAY) and stays high until BREADY. ARREADY is high while no read data is pending. RVALID rises on the cycle after the address is accepted, with RRESP = 0, and RVALID and RDATA stay stable until RREADY.
- R2: A write to offset 0x00 updates the accumulator once with the full 32-bit word, for any WSTRB. The update is processed MSB-first with polynomial 0x04C11DB7 and no final XOR. From seed 0xFFFFFFFF, the word 0x12345678 gives 0xDF8A8A2B.
- R3: A read of offset 0x00 returns the accumulator and never the word last written.
- R4: Offset 0x04 is a 32-bit read/write scratch register. Writing it leaves the accumulator unchanged.
- R5: Offset 0x08 is the control register. Writing 1 to bit 0, with WSTRB[0] set, reloads the accumulator from the seed register, and bit 0 always reads 0. Bits 4:3 (size field), 6:5 (input order) and 7 (output mirror) are stored and read back. All other bits read 0.
- R6: Input order field 6:5 selects how the word is reordered before the update: 0 leaves it unchanged, 1 mirrors bits within each byte, 2 mirrors within each half-word, 3 mirrors all 32 bits.
- R7: When control bit 7 is 1, a read of offset 0x00 returns the accumulator with all 32 bits mirrored. The accumulator itself does not change.
- R8: Offset 0x10 is the read/write seed register. It and the accumulator reset to 0xFFFFFFFF, and the scratch and control registers reset to 0.
- R9: Offset 0x14 always reads 0x04C11DB7, and writes to it change nothing.
- R10: Offsets 0x0C, 0x18 and 0x1C read as 0 and answer OKAY. Writes to them change no register.
- R11: For the scratch, control and seed registers, each WSTRB bit enables writing its byte lane. Lanes with the strobe low keep their old value.
- R12: Writes to the data register made one after another, with no reads between them, each produce exactly one update, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_awaddr_i | input | 5 | Write address |
| s_awvalid_i | input | 1 | Write address valid |
| s_awready_o | output | 1 | Write address ready |
| s_wdata_i | input | 32 | Write data |
| s_wstrb_i | input | 4 | Write byte strobes |
| s_wvalid_i | input | 1 | Write data valid |
| s_wready_o | output | 1 | Write data ready |
| s_bresp_o | output | 2 | Write response, always OKAY |
| s_bvalid_o | output | 1 | Write response valid |
| s_bready_i | input | 1 | Write response ready |
| s_araddr_i | input | 5 | Read address |
| s_arvalid_i | input | 1 | Read address valid |
| s_arready_o | output | 1 | Read address ready |
| s_rdata_o | output | 32 | Read data |
| s_rresp_o | output | 2 | Read response, always OKAY |
| s_rvalid_o | output | 1 | Read data valid |
| s_rready_i | input | 1 | Read data ready |

## Verification
The bench checks the checksum of a fixed word against a hand-worked value. A design that shifted LSB-first or applied a final XOR would miss that value.

It then drives every input order with the output mirror both on and off. A design that mirrored the wrong group width, or mirrored the stored accumulator instead of only the read path, would drift from the model on the next word.

Partial strobes on the seed and control registers catch lane mix-ups. Writes to the polynomial word and to unused offsets, each followed by reads, catch decoding that aliases onto live registers. Holding BREADY and RREADY low catches a response that drops or changes early.

A restart write that set other control fields at the same time, and long random runs of back-to-back data writes, would expose a lost or doubled update.

// File: rtl/crc_pkg.sv
package crc_pkg;
  localparam int unsigned CRC_W = 32;

  // word index = address[4:2]
  localparam logic [2:0] IDX_DATA    = 3'd0;
  localparam logic [2:0] IDX_SCRATCH = 3'd1;
  localparam logic [2:0] IDX_CTRL    = 3'd2;
  localparam logic [2:0] IDX_SEED    = 3'd4;
  localparam logic [2:0] IDX_POLY    = 3'd5;

  localparam int unsigned CTRL_RESTART = 0;
  localparam int unsigned CTRL_ORD_LO  = 5;
  localparam int unsigned CTRL_MIRROR  = 7;
  localparam logic [CRC_W-1:0] CTRL_KEEP = 32'h0000_00F8;

  localparam logic [1:0] RESP_OKAY = 2'b00;

  function automatic logic [CRC_W-1:0] crc_fold(input logic [CRC_W-1:0] c,
                                                input logic [CRC_W-1:0] d,
                                                input logic [CRC_W-1:0] poly);
    logic [CRC_W-1:0] r;
    logic fb;
    r = c;
    for (int i = CRC_W - 1; i >= 0; i--) begin
      fb = r[CRC_W-1] ^ d[i];
      r  = {r[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
    end
    return r;
  endfunction

  function automatic logic [CRC_W-1:0] mirror_all(input logic [CRC_W-1:0] d);
    logic [CRC_W-1:0] r;
    for (int i = 0; i < CRC_W; i++) r[i] = d[CRC_W-1-i];
    return r;
  endfunction
endpackage

// File: rtl/crc_axil_slave.sv
module crc_axil_slave #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned STRB_W = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] awaddr_i,
  input  logic              awvalid_i,
  output logic              awready_o,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [STRB_W-1:0] wstrb_i,
  input  logic              wvalid_i,
  output logic              wready_o,
  output logic [1:0]        bresp_o,
  output logic              bvalid_o,
  input  logic              bready_i,
  input  logic [ADDR_W-1:0] araddr_i,
  input  logic              arvalid_i,
  output logic              arready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [1:0]        rresp_o,
  output logic              rvalid_o,
  input  logic              rready_i,
  output logic              wr_fire_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [STRB_W-1:0] wr_strb_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i
);
  import crc_pkg::*;

  logic bvalid_q, rvalid_q, rd_fire;
  logic [DATA_W-1:0] rdata_q;

  // address and data taken together, only when no response is pending
  assign wr_fire_o = awvalid_i & wvalid_i & ~bvalid_q;
  assign awready_o = wr_fire_o;
  assign wready_o  = wr_fire_o;
  assign wr_addr_o = awaddr_i;
  assign wr_data_o = wdata_i;
  assign wr_strb_o = wstrb_i;

  assign arready_o = ~rvalid_q;
  assign rd_fire   = arvalid_i & ~rvalid_q;
  assign rd_addr_o = araddr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bvalid_q <= 1'b0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      if (wr_fire_o)     bvalid_q <= 1'b1;
      else if (bready_i) bvalid_q <= 1'b0;
      if (rd_fire) begin
        rvalid_q <= 1'b1;
        rdata_q  <= rd_data_i;
      end else if (rready_i) begin
        rvalid_q <= 1'b0;
      end
    end
  end

  assign bvalid_o = bvalid_q;
  assign bresp_o  = RESP_OKAY;
  assign rvalid_o = rvalid_q;
  assign rdata_o  = rdata_q;
  assign rresp_o  = RESP_OKAY;

  AST_BRESP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bvalid_o && !bready_i |=> bvalid_o);  // R1
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o && !rready_i |=> rvalid_o && $stable(rdata_o));  // R1
endmodule

// File: rtl/crc_regfile.sv
module crc_regfile #(
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned DATA_W   = 32,
  parameter logic [DATA_W-1:0] POLY     = 32'h04C1_1DB7,
  parameter logic [DATA_W-1:0] SEED_RST = 32'hFFFF_FFFF,
  localparam int unsigned STRB_W = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_fire_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [STRB_W-1:0] wr_strb_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [DATA_W-1:0] crc_i,
  output logic              step_o,
  output logic [DATA_W-1:0] step_word_o,
  output logic              reload_o,
  output logic [DATA_W-1:0] seed_o,
  output logic [1:0]        order_o
);
  import crc_pkg::*;

  logic [DATA_W-1:0] scratch_q, ctrl_q, seed_q, lane_mask;
  logic [2:0] wr_idx, rd_idx;
  logic [1:0] unused_addr;

  assign wr_idx      = wr_addr_i[4:2];
  assign rd_idx      = rd_addr_i[4:2];
  assign unused_addr = wr_addr_i[1:0] ^ rd_addr_i[1:0];

  for (genvar b = 0; b < STRB_W; b++) begin : g_lane
    assign lane_mask[b*8 +: 8] = {8{wr_strb_i[b]}};
  end

  function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old_v);
    return (old_v & ~lane_mask) | (wr_data_i & lane_mask);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scratch_q <= '0;
      ctrl_q    <= '0;
      seed_q    <= SEED_RST;
    end else if (wr_fire_i) begin
      case (wr_idx)
        IDX_SCRATCH: scratch_q <= merge(scratch_q);
        IDX_CTRL:    ctrl_q    <= merge(ctrl_q) & CTRL_KEEP;
        IDX_SEED:    seed_q    <= merge(seed_q);
        default: ;
      endcase
    end
  end

  assign step_o      = wr_fire_i && (wr_idx == IDX_DATA);
  assign step_word_o = wr_data_i;
  assign reload_o    = wr_fire_i && (wr_idx == IDX_CTRL) && wr_strb_i[0] && wr_data_i[CTRL_RESTART];
  assign seed_o      = seed_q;
  assign order_o     = ctrl_q[CTRL_ORD_LO +: 2];

  always_comb begin
    case (rd_idx)
      IDX_DATA:    rd_data_o = ctrl_q[CTRL_MIRROR] ? mirror_all(crc_i) : crc_i;
      IDX_SCRATCH: rd_data_o = scratch_q;
      IDX_CTRL:    rd_data_o = ctrl_q;
      IDX_SEED:    rd_data_o = seed_q;
      IDX_POLY:    rd_data_o = POLY;
      default:     rd_data_o = '0;
    endcase
  end

  AST_SEED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_fire_i && wr_idx == IDX_SEED) |=> $stable(seed_o));  // R8
endmodule

// File: rtl/crc_engine.sv
module crc_engine #(
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] POLY     = 32'h04C1_1DB7,
  parameter logic [DATA_W-1:0] SEED_RST = 32'hFFFF_FFFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic [1:0]        order_i,
  input  logic              reload_i,
  input  logic [DATA_W-1:0] seed_i,
  output logic [DATA_W-1:0] crc_o
);
  import crc_pkg::*;

  localparam int unsigned G_BYTE = 8;
  localparam int unsigned G_HALF = DATA_W / 2;

  logic [DATA_W-1:0] acc_q, ordered;
  logic [DATA_W-1:0] mir [4];

  // mir[k]: bits mirrored inside groups of 8, 16, DATA_W (k=1..3)
  assign mir[0] = word_i;
  for (genvar k = 1; k < 4; k++) begin : g_mir
    localparam int unsigned G = (k == 1) ? G_BYTE : (k == 2) ? G_HALF : DATA_W;
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      assign mir[k][i] = word_i[(i / G) * G + (G - 1) - (i % G)];
    end
  end

  assign ordered = mir[order_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       acc_q <= SEED_RST;
    else if (reload_i) acc_q <= seed_i;
    else if (step_i)   acc_q <= crc_fold(acc_q, ordered, POLY);
  end

  assign crc_o = acc_q;

  AST_ACC_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i && !reload_i |=> $stable(crc_o));  // R4
  AST_ONE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({step_i, reload_i}));  // R12
endmodule

// File: rtl/crc_calc_axil.sv
module crc_calc_axil #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] POLY     = 32'h04C1_1DB7,
  parameter logic [DATA_W-1:0] SEED_RST = 32'hFFFF_FFFF,
  localparam int unsigned STRB_W = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] s_awaddr_i,
  input  logic              s_awvalid_i,
  output logic              s_awready_o,
  input  logic [DATA_W-1:0] s_wdata_i,
  input  logic [STRB_W-1:0] s_wstrb_i,
  input  logic              s_wvalid_i,
  output logic              s_wready_o,
  output logic [1:0]        s_bresp_o,
  output logic              s_bvalid_o,
  input  logic              s_bready_i,
  input  logic [ADDR_W-1:0] s_araddr_i,
  input  logic              s_arvalid_i,
  output logic              s_arready_o,
  output logic [DATA_W-1:0] s_rdata_o,
  output logic [1:0]        s_rresp_o,
  output logic              s_rvalid_o,
  input  logic              s_rready_i
);
  logic              wr_fire, step, reload;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data, crc, step_word, seed;
  logic [STRB_W-1:0] wr_strb;
  logic [1:0]        order;

  crc_axil_slave #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk_i, .rst_ni,
    .awaddr_i(s_awaddr_i), .awvalid_i(s_awvalid_i), .awready_o(s_awready_o),
    .wdata_i(s_wdata_i), .wstrb_i(s_wstrb_i), .wvalid_i(s_wvalid_i), .wready_o(s_wready_o),
    .bresp_o(s_bresp_o), .bvalid_o(s_bvalid_o), .bready_i(s_bready_i),
    .araddr_i(s_araddr_i), .arvalid_i(s_arvalid_i), .arready_o(s_arready_o),
    .rdata_o(s_rdata_o), .rresp_o(s_rresp_o), .rvalid_o(s_rvalid_o), .rready_i(s_rready_i),
    .wr_fire_o(wr_fire), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_strb_o(wr_strb),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data)
  );

  crc_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .POLY(POLY), .SEED_RST(SEED_RST)) u_regs (
    .clk_i, .rst_ni,
    .wr_fire_i(wr_fire), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .wr_strb_i(wr_strb),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .crc_i(crc),
    .step_o(step), .step_word_o(step_word), .reload_o(reload), .seed_o(seed), .order_o(order)
  );

  crc_engine #(.DATA_W(DATA_W), .POLY(POLY), .SEED_RST(SEED_RST)) u_core (
    .clk_i, .rst_ni,
    .step_i(step), .word_i(step_word), .order_i(order),
    .reload_i(reload), .seed_i(seed), .crc_o(crc)
  );
endmodule

// File: tb/sim_crc_calc_axil.sv
module sim_crc_calc_axil;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] awaddr = '0, araddr = '0;
  logic awvalid = 0, wvalid = 0, bready = 1, arvalid = 0, rready = 1;
  logic [31:0] wdata = '0;
  logic [3:0] wstrb = '0;
  logic awready, wready, bvalid, arready, rvalid;
  logic [1:0] bresp, rresp;
  logic [31:0] rdata;
  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] m_acc = 32'hFFFF_FFFF, m_scr = '0, m_ctrl = '0, m_seed = 32'hFFFF_FFFF;

  always #2.5 clk = ~clk;

  crc_calc_axil u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .s_awaddr_i(awaddr), .s_awvalid_i(awvalid), .s_awready_o(awready),
    .s_wdata_i(wdata), .s_wstrb_i(wstrb), .s_wvalid_i(wvalid), .s_wready_o(wready),
    .s_bresp_o(bresp), .s_bvalid_o(bvalid), .s_bready_i(bready),
    .s_araddr_i(araddr), .s_arvalid_i(arvalid), .s_arready_o(arready),
    .s_rdata_o(rdata), .s_rresp_o(rresp), .s_rvalid_o(rvalid), .s_rready_i(rready)
  );

  function automatic logic [31:0] brev(input logic [31:0] d);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[31-i] = d[i];
    return r;
  endfunction

  // group mirror = full mirror then undo the group order
  function automatic logic [31:0] order_word(input logic [31:0] d, input logic [1:0] m);
    logic [31:0] f;
    f = brev(d);
    case (m)
      2'd0: return d;
      2'd1: return {f[7:0], f[15:8], f[23:16], f[31:24]};
      2'd2: return {f[15:0], f[31:16]};
      default: return f;
    endcase
  endfunction

  function automatic logic [31:0] crc_ref(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 31; i >= 0; i--) begin
      if (r[31] != d[i]) r = (r << 1) ^ 32'h04C1_1DB7;
      else               r = r << 1;
    end
    return r;
  endfunction

  function automatic logic [31:0] lanes(input logic [31:0] o, input logic [31:0] n, input logic [3:0] s);
    logic [31:0] r;
    r = o;
    for (int b = 0; b < 4; b++) if (s[b]) r[b*8 +: 8] = n[b*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] model_rd(input logic [4:0] a);
    case (a[4:2])
      3'd0: return m_ctrl[7] ? brev(m_acc) : m_acc;
      3'd1: return m_scr;
      3'd2: return m_ctrl;
      3'd4: return m_seed;
      3'd5: return 32'h04C1_1DB7;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic axi_wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    awaddr = a; wdata = d; wstrb = s; awvalid = 1; wvalid = 1;
    @(negedge clk);
    awvalid = 0; wvalid = 0;
    check("R1 bvalid", {31'd0, bvalid}, 32'd1);
    check("R1 bresp", {30'd0, bresp}, 32'd0);
  endtask

  task automatic do_wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] s);
    axi_wr(a, d, s);
    case (a[4:2])
      3'd0: m_acc = crc_ref(m_acc, order_word(d, m_ctrl[6:5]));
      3'd1: m_scr = lanes(m_scr, d, s);
      3'd2: begin
        if (s[0] && d[0]) m_acc = m_seed;
        m_ctrl = lanes(m_ctrl, d, s) & 32'hF8;
      end
      3'd4: m_seed = lanes(m_seed, d, s);
      default: ;
    endcase
  endtask

  task automatic axi_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    araddr = a; arvalid = 1;
    @(negedge clk);
    arvalid = 0;
    check("R1 rvalid", {31'd0, rvalid}, 32'd1);
    check("R1 rresp", {30'd0, rresp}, 32'd0);
    d = rdata;
  endtask

  task automatic rd_chk(input string req, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] v;
    axi_rd(a, v);
    check(req, v, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R8 reset values
    rd_chk("R8 acc reset", 5'h00, 32'hFFFF_FFFF);
    rd_chk("R8 seed reset", 5'h10, 32'hFFFF_FFFF);
    rd_chk("R8 scratch reset", 5'h04, 32'h0);
    rd_chk("R8 ctrl reset", 5'h08, 32'h0);
    rd_chk("R9 poly", 5'h14, 32'h04C1_1DB7);
    // R2 known vector, R3 read returns crc
    do_wr(5'h00, 32'h1234_5678, 4'hF);
    rd_chk("R2 R3 known word", 5'h00, 32'hDF8A_8A2B);
    // R2 strobes ignored on data
    do_wr(5'h00, 32'hCAFE_F00D, 4'h1);
    rd_chk("R2 partial strobe data", 5'h00, model_rd(5'h00));
    // R4 scratch no effect
    do_wr(5'h04, 32'hDEAD_BEEF, 4'hF);
    rd_chk("R4 scratch read", 5'h04, 32'hDEAD_BEEF);
    rd_chk("R4 crc unchanged", 5'h00, model_rd(5'h00));
    // R11 strobe lanes on seed
    do_wr(5'h10, 32'hAABB_CCDD, 4'b0101);
    rd_chk("R11 seed lanes", 5'h10, 32'hFFBB_FFDD);
    // R5 restart with fields
    do_wr(5'h08, 32'hFFFF_FFFF, 4'hF);
    rd_chk("R5 ctrl readback", 5'h08, 32'h0000_00F8);
    rd_chk("R5 R7 reload mirrored", 5'h00, brev(32'hFFBB_FFDD));
    do_wr(5'h08, 32'h0000_0001, 4'h2);
    rd_chk("R5 restart needs strobe0", 5'h08, 32'h0000_00F8);
    // R9 poly write ignored, R10 holes
    do_wr(5'h14, 32'h0, 4'hF);
    rd_chk("R9 poly after write", 5'h14, 32'h04C1_1DB7);
    do_wr(5'h0C, 32'h1111_1111, 4'hF);
    do_wr(5'h18, 32'h2222_2222, 4'hF);
    rd_chk("R10 hole 0C", 5'h0C, 32'h0);
    rd_chk("R10 hole 1C", 5'h1C, 32'h0);
    rd_chk("R10 scratch intact", 5'h04, 32'hDEAD_BEEF);
    rd_chk("R10 seed intact", 5'h10, 32'hFFBB_FFDD);
    // R6 R7 every order, both mirror settings
    for (int m = 0; m < 8; m++) begin
      do_wr(5'h08, {24'd0, m[2], m[1:0], 5'b00001}, 4'hF);
      do_wr(5'h00, 32'h8001_4C3A + 32'(m), 4'hF);
      do_wr(5'h00, 32'h0F0F_3355, 4'hF);
      rd_chk(m[2] ? "R7 mirrored result" : "R6 order mode", 5'h00, model_rd(5'h00));
    end
    // R1 held responses
    bready = 0;
    axi_wr(5'h04, 32'h5A5A_5A5A, 4'hF);
    m_scr = 32'h5A5A_5A5A;
    repeat (3) @(negedge clk);
    check("R1 bvalid held", {31'd0, bvalid}, 32'd1);
    bready = 1;
    @(negedge clk);
    check("R1 bvalid drop", {31'd0, bvalid}, 32'd0);
    rready = 0;
    axi_rd(5'h04, v);
    repeat (3) @(negedge clk);
    check("R1 rvalid held", {31'd0, rvalid}, 32'd1);
    check("R1 rdata held", rdata, 32'h5A5A_5A5A);
    rready = 1;
    @(negedge clk);
    // R12 back-to-back data writes
    do_wr(5'h08, 32'h1, 4'hF);
    for (int i = 0; i < 6; i++) do_wr(5'h00, 32'h0101_0101 * 32'(i + 1), 4'hF);
    rd_chk("R12 back to back", 5'h00, model_rd(5'h00));
    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [4:0] a;
      a = {3'($urandom_range(0, 7)), 2'($urandom)};
      if ($urandom_range(0, 2) != 0)
        do_wr(a, $urandom, 4'($urandom));
      else
        rd_chk("R2 R6 R11 random", a, model_rd(a));
    end
    for (int k = 0; k < 8; k++) rd_chk("R3 R5 R8 final", 5'(k * 4), model_rd(5'(k * 4)));
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule